// File: doc/BRIEF.md
# Conditional Execution Flag Unit

This block keeps the four condition flags (negative, zero, carry, overflow) of a processor pipeline. For every operation issued to it, the block does two things. It tests the operation's 4-bit condition code against the flags currently held and reports whether the operation commits. If the operation commits and asks for a flag update, it also computes the new flags from the ALU result and the ALU's carry and overflow outputs. An operation whose test fails is squashed and has no effect on the flags.

Operations fall into four classes: add, subtract, logical and move. Add and subtract replace all four flags. Logical and move replace N and Z only, and keep C and V. A separate flags-only write port loads the flag field directly, for a move-to-status instruction. The flags appear in the top four bits of a 32-bit status word.

The flag register feeds the condition test directly. An operation therefore sees the flags written by the operation issued in the cycle just before it, with no stall cycle between them.

Top module: `cond_flag_unit`

## Requirements
- R1: While `rst` is high, the block clears all four flags. After the first clock edge in reset, `status_o` reads 0 and `commit_o` reads 0.
- R2: `commit_o` is registered. It is high one cycle after an issue cycle (`op_valid_i`=1) whose condition passes, and low otherwise. The condition codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C\|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z\|(N!=V).
- R3: Condition codes 14 and 15 always pass, whatever the flags hold.
- R4: An operation whose condition fails leaves all four flags unchanged, even when its set-flags bit is 1.
- R5: An operation issued with `set_flags_i`=0 still commits when its condition passes, and all four flags keep their previous values.
- R6: A committed add-class operation (`op_class_i`=0) with set-flags updates the flags as follows: N takes the result MSB, Z is 1 exactly when the result is zero, C takes `alu_cout_i`, and V takes `alu_ovf_i`. For example, 0+0 gives Z=1 and C=0.
- R7: A committed subtract-class operation (`op_class_i`=1) with set-flags updates N, Z and V as in R6. `alu_cout_i` then carries the borrow, and C is set to its inverse.
- R8: A committed logical-class (`op_class_i`=2) or move-class (`op_class_i`=3) operation with set-flags updates N and Z as in R6 and keeps C and V unchanged.
- R9: A pulse on `fwr_i` loads `fwr_nzcv_i` (N at bit 3 down to V at bit 0) into the flags on the next edge. In the same cycle it takes priority over any flag update by an operation.
- R10: The flags written at an edge are used by the condition test of an operation issued in the very next cycle.
- R11: `status_o` places N at bit 31, Z at bit 30, C at bit 29 and V at bit 28. Bits 27 to 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | An operation is issued this cycle |
| cond_i | input | 4 | Condition code of the operation |
| set_flags_i | input | 1 | Operation requests a flag update |
| op_class_i | input | 2 | 0 add, 1 subtract, 2 logical, 3 move |
| alu_res_i | input | DATA_W | ALU result |
| alu_cout_i | input | 1 | Carry-out for add, borrow-out for subtract |
| alu_ovf_i | input | 1 | Signed overflow from the ALU |
| fwr_i | input | 1 | Flags-only status write |
| fwr_nzcv_i | input | 4 | Flag values to write (N,Z,C,V) |
| commit_o | output | 1 | Registered commit enable for last cycle's operation |
| status_o | output | STAT_W | Status word with flags in top four bits |

## Verification
Both results of an issue cycle appear one edge later: `commit_o` and the updated flags in `status_o` are registered at the same edge. The bench drives inputs 1 ns after a rising edge and samples outputs 1 ns after the next rising edge, so each check sees exactly the issue it follows. Back-to-back issues use the same timing. This shows that the second operation's commit depends on flags written by the first, with no cycle between them. The bench sweeps every pair of flag value and condition code, and runs add and subtract over a set of operand corner values whose flags it computes arithmetically.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  typedef enum logic [1:0] {
    OPC_ADD   = 2'd0,
    OPC_SUB   = 2'd1,
    OPC_LOGIC = 2'd2,
    OPC_MOVE  = 2'd3
  } opc_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam int NZCV_W = 4;
endpackage

// File: rtl/cfu_cond_eval.sv
module cfu_cond_eval
  import cfu_pkg::*;
(
  input  nzcv_t      flags,
  input  logic [3:0] cond,
  output logic       pass
);
  logic base;
  logic nv_eq;

  assign nv_eq = (flags.n == flags.v);

  // Codes come in pairs; the odd member of each pair is the complement.
  always_comb begin
    unique case (cond[3:1])
      3'd0:    base = flags.z;
      3'd1:    base = flags.c;
      3'd2:    base = flags.n;
      3'd3:    base = flags.v;
      3'd4:    base = flags.c & ~flags.z;
      3'd5:    base = nv_eq;
      3'd6:    base = ~flags.z & nv_eq;
      default: base = 1'b1;
    endcase
    pass = (cond[3:1] == 3'd7) ? 1'b1 : (base ^ cond[0]);
  end
endmodule

// File: rtl/cfu_flag_next.sv
module cfu_flag_next
  import cfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              cur_c,
  input  logic              cur_v,
  input  opc_e              opc,
  input  logic [DATA_W-1:0] res,
  input  logic              cout,
  input  logic              ovf,
  output nzcv_t             nxt
);
  always_comb begin
    nxt.n = res[DATA_W-1];
    nxt.z = (res == '0);
    unique case (opc)
      OPC_ADD: begin
        nxt.c = cout;
        nxt.v = ovf;
      end
      OPC_SUB: begin
        nxt.c = ~cout;
        nxt.v = ovf;
      end
      default: begin
        nxt.c = cur_c;
        nxt.v = cur_v;
      end
    endcase
  end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid_i,
  input  logic [3:0]        cond_i,
  input  logic              set_flags_i,
  input  logic [1:0]        op_class_i,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic              alu_cout_i,
  input  logic              alu_ovf_i,
  input  logic              fwr_i,
  input  logic [3:0]        fwr_nzcv_i,
  output logic              commit_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int LOW_W = STAT_W - NZCV_W;

  nzcv_t flags_q;
  nzcv_t flags_nxt;
  logic  cond_pass;
  logic  upd_en;
  logic  commit_q;

  cfu_cond_eval u_cond (
    .flags (flags_q),
    .cond  (cond_i),
    .pass  (cond_pass)
  );

  cfu_flag_next #(.DATA_W(DATA_W)) u_next (
    .cur_c (flags_q.c),
    .cur_v (flags_q.v),
    .opc   (opc_e'(op_class_i)),
    .res   (alu_res_i),
    .cout  (alu_cout_i),
    .ovf   (alu_ovf_i),
    .nxt   (flags_nxt)
  );

  assign upd_en = op_valid_i & cond_pass & set_flags_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q  <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= op_valid_i & cond_pass;
      if (fwr_i)
        flags_q <= nzcv_t'(fwr_nzcv_i);
      else if (upd_en)
        flags_q <= flags_nxt;
    end
  end

  assign commit_o = commit_q;
  assign status_o = {flags_q, {LOW_W{1'b0}}};
endmodule

// File: rtl/cfu_checker.sv
module cfu_checker #(
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid_i,
  input logic [3:0]        cond_i,
  input logic              set_flags_i,
  input logic [1:0]        op_class_i,
  input logic              fwr_i,
  input logic [3:0]        fwr_nzcv_i,
  input logic              commit_o,
  input logic [STAT_W-1:0] status_o
);
  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (status_o == '0 && !commit_o)); // R1

  AST_IDLE_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i |=> !commit_o); // R2

  AST_ALWAYS_PASS: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && cond_i[3:1] == 3'd7) |=> commit_o); // R3

  AST_EQ_SQUASH: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && cond_i == 4'd0 && !status_o[STAT_W-2]) |=> !commit_o); // R4

  AST_SQUASH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && cond_i == 4'd0 && !status_o[STAT_W-2] && !fwr_i)
      |=> $stable(status_o)); // R4

  AST_NOSET_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && !set_flags_i && !fwr_i) |=> $stable(status_o)); // R5

  AST_LOGIC_KEEP_CV: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && set_flags_i && op_class_i[1] && !fwr_i)
      |=> (status_o[STAT_W-3 -: 2] == $past(status_o[STAT_W-3 -: 2]))); // R8

  AST_FLAG_WRITE: assert property (@(posedge clk) disable iff (rst)
    fwr_i |=> (status_o[STAT_W-1 -: 4] == $past(fwr_nzcv_i))); // R9

  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    status_o[STAT_W-5:0] == '0); // R11
endmodule

bind cond_flag_unit cfu_checker #(.STAT_W(STAT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_valid_i  (op_valid_i),
  .cond_i      (cond_i),
  .set_flags_i (set_flags_i),
  .op_class_i  (op_class_i),
  .fwr_i       (fwr_i),
  .fwr_nzcv_i  (fwr_nzcv_i),
  .commit_o    (commit_o),
  .status_o    (status_o)
);

// File: tb/cond_flag_unit_tb.sv
`timescale 1ns/1ps
module cond_flag_unit_tb;
  localparam int DW = 32;
  localparam int SW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          op_valid_i;
  logic [3:0]    cond_i;
  logic          set_flags_i;
  logic [1:0]    op_class_i;
  logic [DW-1:0] alu_res_i;
  logic          alu_cout_i;
  logic          alu_ovf_i;
  logic          fwr_i;
  logic [3:0]    fwr_nzcv_i;
  logic          commit_o;
  logic [SW-1:0] status_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  cond_flag_unit #(.DATA_W(DW), .STAT_W(SW)) u_dut (
    .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .cond_i(cond_i),
    .set_flags_i(set_flags_i), .op_class_i(op_class_i), .alu_res_i(alu_res_i),
    .alu_cout_i(alu_cout_i), .alu_ovf_i(alu_ovf_i), .fwr_i(fwr_i),
    .fwr_nzcv_i(fwr_nzcv_i), .commit_o(commit_o), .status_o(status_o)
  );

  function automatic bit exp_pass(input logic [3:0] f, input logic [3:0] c);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [3:0] c, input logic s, input logic [1:0] opc,
                       input logic [DW-1:0] res, input logic cy, input logic ov,
                       input logic w, input logic [3:0] wf);
    op_valid_i = v; cond_i = c; set_flags_i = s; op_class_i = opc;
    alu_res_i = res; alu_cout_i = cy; alu_ovf_i = ov; fwr_i = w; fwr_nzcv_i = wf;
    @(posedge clk); #1;
    op_valid_i = 1'b0; fwr_i = 1'b0; set_flags_i = 1'b0;
  endtask

  task automatic wr_flags(input logic [3:0] f);
    issue(1'b0, 4'd14, 1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b1, f);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] ops [5];
    ops[0] = 32'h0000_0000; ops[1] = 32'h0000_0001; ops[2] = 32'h7FFF_FFFF;
    ops[3] = 32'h8000_0000; ops[4] = 32'hFFFF_FFFF;

    rst = 1'b1; op_valid_i = 0; cond_i = 0; set_flags_i = 0; op_class_i = 0;
    alu_res_i = 0; alu_cout_i = 0; alu_ovf_i = 0; fwr_i = 0; fwr_nzcv_i = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 status", status_o, '0);
    check("R1 commit", {31'b0, commit_o}, 32'd0);
    rst = 1'b0;

    // R2 R3 R5 R9: every flag value against every condition code
    for (int f = 0; f < 16; f++) begin
      wr_flags(4'(f));
      check("R9 write", status_o, {4'(f), 28'b0});
      for (int c = 0; c < 16; c++) begin
        issue(1'b1, 4'(c), 1'b0, 2'd0, 32'h1, 1'b1, 1'b1, 1'b0, 4'd0);
        check(c >= 14 ? "R3 always" : "R2 cond", {31'b0, commit_o},
              {31'b0, exp_pass(4'(f), 4'(c))});
        check("R5 flags held", status_o, {4'(f), 28'b0});
      end
    end

    // R11 bit placement: carry alone at bit 29, CS passes
    wr_flags(4'b0010);
    check("R11 carry pos", status_o, 32'h2000_0000);
    issue(1'b1, 4'd2, 1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b0, 4'd0);
    check("R11 cs commit", {31'b0, commit_o}, 32'd1);
    wr_flags(4'b1001);
    check("R11 n v pos", status_o, 32'h9000_0000);

    // R6 add and R7 subtract over operand corners
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 5; j++) begin
        logic [DW:0]   sum;
        logic [DW-1:0] dif;
        logic          ov, bw;
        sum = {1'b0, ops[i]} + {1'b0, ops[j]};
        ov  = (ops[i][DW-1] == ops[j][DW-1]) && (sum[DW-1] != ops[i][DW-1]);
        wr_flags(4'((i + j) & 1 ? 4'b1111 : 4'b0000));
        issue(1'b1, 4'd14, 1'b1, 2'd0, sum[DW-1:0], sum[DW], ov, 1'b0, 4'd0);
        check("R6 add", status_o,
              {sum[DW-1], sum[DW-1:0] == '0, sum[DW], ov, 28'b0});
        dif = ops[i] - ops[j];
        bw  = ops[i] < ops[j];
        ov  = (ops[i][DW-1] != ops[j][DW-1]) && (dif[DW-1] != ops[i][DW-1]);
        issue(1'b1, 4'd15, 1'b1, 2'd1, dif, bw, ov, 1'b0, 4'd0);
        check("R7 sub", status_o, {dif[DW-1], dif == '0, ~bw, ov, 28'b0});
      end
    end

    // R8 logical and move keep C and V
    for (int k = 0; k < 4; k++) begin
      logic [DW-1:0] r;
      logic [1:0]    cv;
      r  = ops[k] ^ ops[k + 1];
      cv = 2'(k);
      wr_flags({2'b00, cv});
      issue(1'b1, 4'd14, 1'b1, (k & 1) ? 2'd3 : 2'd2, r, ~cv[1], ~cv[0], 1'b0, 4'd0);
      check("R8 logic/move", status_o, {r[DW-1], r == '0, cv, 28'b0});
    end

    // R4 failed condition with set-flags leaves flags alone
    wr_flags(4'b0000);
    issue(1'b1, 4'd0, 1'b1, 2'd0, '0, 1'b1, 1'b1, 1'b0, 4'd0);
    check("R4 squash commit", {31'b0, commit_o}, 32'd0);
    check("R4 squash flags", status_o, 32'h0);
    wr_flags(4'b0100);
    issue(1'b1, 4'd12, 1'b1, 2'd1, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 4'd0);
    check("R4 gt squash flags", status_o, 32'h4000_0000);

    // R10 back-to-back: flags set by one op steer the next
    wr_flags(4'b0000);
    issue(1'b1, 4'd14, 1'b1, 2'd0, '0, 1'b0, 1'b0, 1'b0, 4'd0);
    check("R10 first commit", {31'b0, commit_o}, 32'd1);
    issue(1'b1, 4'd0, 1'b1, 2'd2, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 4'd0);
    check("R10 eq next", {31'b0, commit_o}, 32'd1);
    issue(1'b1, 4'd4, 1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b0, 4'd0);
    check("R10 mi next", {31'b0, commit_o}, 32'd1);
    issue(1'b1, 4'd1, 1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b0, 4'd0);
    check("R10 ne next", {31'b0, commit_o}, 32'd1);

    // R9 write wins over same-cycle op update
    wr_flags(4'b0000);
    issue(1'b1, 4'd14, 1'b1, 2'd0, '0, 1'b1, 1'b1, 1'b1, 4'b1000);
    check("R9 priority", status_o, 32'h8000_0000);
    check("R9 op commit", {31'b0, commit_o}, 32'd1);

    // R1 reset again clears flags
    wr_flags(4'b1111);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1 rerun status", status_o, '0);
    rst = 1'b0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule